// File: doc/BRIEF.md
# Serial Engine Run/Pause State Controller

This block is the control-and-status core of a serial protocol engine. It holds the engine's run state, which is one of reset, run or pause, behind a small synchronous register port. Software requests a new state by writing to the state register. The block then lowers a valid flag for a fixed settle time and commits the new state. Software polls until valid is high and the field shows the target state before it writes again. A pause can only be entered from run. A software-reset register forces the engine back to the reset state and sends a one-cycle clear pulse to the datapath.

Three service flags record events from the datapath: the output side needs service, the input side needs service, and input is done. Software clears each flag by writing 1 to its bit. A mask register selects which flags drive the level interrupt. Two plain gate outputs tell the datapath when it may move FIFO entries (settled run) and tell firmware when it may refill (settled pause).

The register port has no back-pressure. A write completes in the cycle it is strobed. A read strobe returns data, with a valid flag, one cycle later.

Top module: `engine_run_ctl`

## Requirements
- R1: The state register is at offset 0. It reads the state in bits 1:0 (reset = 0, run = 1, pause = 3), the valid flag in bit 2 and the master-ready flag in bit 4. All other bits read 0. After reset it reads state 0 with valid 1. Unmapped offsets read 0. Read data and a valid strobe appear one cycle after the read strobe.
- R2: An accepted state write drops valid for exactly two cycles. During that time the old state stays visible. Valid then returns high with the new state.
- R3: A request for pause is accepted only when the settled state is run. Requests for pause from any other state, and requests for code 2, are ignored: valid stays high and the state is unchanged. Requests for reset and run are accepted from any settled state.
- R4: State writes that arrive while valid is low are ignored.
- R5: Writing a value with bit 0 set to the soft-reset register (offset 1) does the following. It forces state reset with valid high, cancels any pending transition, clears all service flags and pulses engine_clear for one cycle. A write with bit 0 clear has no effect.
- R6: The service-flag register (offset 2) shows the output-service flag in bit 8, the input-service flag in bit 9 and the input-done flag in bit 11. Each flag is set by its event input one cycle after the event. Writing 1 to a flag's bit clears that flag. Writing 0 leaves it unchanged.
- R7: When an event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: irq is high whenever any flag is set and enabled in the mask register (offset 3, same bit positions). It stays high until the enabled flags are cleared. Flags that are not enabled never raise irq. Soft reset leaves the mask unchanged.
- R9: move_ok is high only when the state is run and valid is high. refill_ok is high only when the state is pause and valid is high.
- R10: The master-ready bit reports master_rdy_i registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data, one cycle after reg_re |
| reg_rvalid | output | 1 | Read data valid |
| master_rdy_i | input | 1 | Engine reports the bus master is ready |
| out_svc_evt | input | 1 | Output side needs service (pulse) |
| in_svc_evt | input | 1 | Input side needs service (pulse) |
| in_done_evt | input | 1 | Input count reached (pulse) |
| move_ok | output | 1 | Datapath may consume or produce FIFO entries |
| refill_ok | output | 1 | Firmware may refill the FIFOs |
| engine_clear | output | 1 | One-cycle clear pulse to the engine |
| irq | output | 1 | Level interrupt |

## Verification
State writes are tried in three patterns: legal moves (reset to run, run to pause, pause to run), illegal moves (pause from reset, code 2), and a second write or a soft reset landing inside the settle window. Together they separate a correct settle length from an off-by-one, and separate proper gating of pause from a design that accepts every code. Flag traffic covers single events, grouped events, partial and zero-valued clear writes, and an event colliding with its own clear. Each mask setting is then tried against set flags to show that irq follows only the enabled ones and that soft reset clears flags but keeps the mask.

// File: rtl/erc_pkg.sv
package erc_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_RSVD  = 2'd2,
    ST_PAUSE = 2'd3
  } run_state_e;

  localparam int VALID_BIT = 2;
  localparam int MRDY_BIT  = 4;

  localparam int NUM_FLAGS = 3;
  // index 0: output service, 1: input service, 2: input done
  localparam int FLAG_POS [NUM_FLAGS] = '{8, 9, 11};

  localparam int OFF_STATE = 0;
  localparam int OFF_SRST  = 1;
  localparam int OFF_OPS   = 2;
  localparam int OFF_IRQEN = 3;

  function automatic logic move_legal(run_state_e cur, run_state_e tgt);
    case (tgt)
      ST_RESET: move_legal = 1'b1;
      ST_RUN:   move_legal = 1'b1;
      ST_PAUSE: move_legal = (cur == ST_RUN);
      default:  move_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/erc_state_seq.sv
module erc_state_seq
  import erc_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] req_code,
  input  logic       srst,
  output run_state_e cur_state,
  output logic       valid
);

  localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);

  run_state_e state_q, pend_q, req_state;
  logic       valid_q;
  logic [CW-1:0] cnt_q;

  assign req_state = run_state_e'(req_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      pend_q  <= ST_RESET;
      valid_q <= 1'b1;
      cnt_q   <= '0;
    end else if (srst) begin
      state_q <= ST_RESET;
      pend_q  <= ST_RESET;
      valid_q <= 1'b1;
      cnt_q   <= '0;
    end else if (valid_q) begin
      if (req && move_legal(state_q, req_state)) begin
        pend_q  <= req_state;
        valid_q <= 1'b0;
        cnt_q   <= CW'(SETTLE - 1);
      end
    end else if (cnt_q == '0) begin
      state_q <= pend_q;
      valid_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cur_state = state_q;
  assign valid     = valid_q;

  // R3: pause is only ever entered from run
  p_pause_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSE && $past(state_q) != ST_PAUSE) |-> $past(state_q) == ST_RUN);

  // R4: while a transition is settling the visible state does not move
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |=> (valid_q || state_q == $past(state_q)));

  // R5: soft reset lands in a settled reset state
  p_srst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (state_q == ST_RESET && valid_q));

  generate
    if (SETTLE >= 2) begin : g_settle_chk
      // R2: valid stays low for more than one cycle
      p_settle_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(valid_q) && !srst) |=> !valid_q);
    end
  endgenerate

endmodule

// File: rtl/erc_flag_bank.sv
module erc_flag_bank
  import erc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt,
  input  logic [NUM_FLAGS-1:0] clr,
  input  logic                 srst,
  input  logic                 en_we,
  input  logic [NUM_FLAGS-1:0] en_wdata,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] en,
  output logic                 irq
);

  genvar i;
  generate
    for (i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flags[i] <= 1'b0;
        else if (srst)   flags[i] <= 1'b0;
        else if (evt[i]) flags[i] <= 1'b1;
        else if (clr[i]) flags[i] <= 1'b0;
      end

      // R6 / R7: an event always leaves its flag set
      p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[i] && !srst) |=> flags[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= en_wdata;
  end

  assign irq = |(flags & en);

  // R8: level interrupt holds until something clears or masks it
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !srst && clr == '0 && !en_we) |=> irq);

endmodule

// File: rtl/erc_reg_port.sv
module erc_reg_port
  import erc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 re,
  input  logic                 master_rdy_i,
  input  run_state_e           cur_state,
  input  logic                 valid,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic [NUM_FLAGS-1:0] en,
  output logic                 st_req,
  output logic [1:0]           st_code,
  output logic                 srst,
  output logic [NUM_FLAGS-1:0] clr,
  output logic                 en_we,
  output logic [NUM_FLAGS-1:0] en_wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid,
  output logic                 engine_clear
);

  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(OFF_STATE);
  localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'(OFF_SRST);
  localparam logic [ADDR_W-1:0] A_OPS   = ADDR_W'(OFF_OPS);
  localparam logic [ADDR_W-1:0] A_IRQEN = ADDR_W'(OFF_IRQEN);

  logic mrdy_q;
  logic ops_we;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wbits;

  assign st_req  = we && (addr == A_STATE);
  assign st_code = wdata[1:0];
  assign srst    = we && (addr == A_SRST) && wdata[0];
  assign ops_we  = we && (addr == A_OPS);
  assign en_we   = we && (addr == A_IRQEN);
  assign unused_wbits = ^wdata;

  genvar i;
  generate
    for (i = 0; i < NUM_FLAGS; i++) begin : g_wbit
      assign clr[i]      = ops_we && wdata[FLAG_POS[i]];
      assign en_wdata[i] = wdata[FLAG_POS[i]];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STATE: begin
        rd_mux[1:0]       = cur_state;
        rd_mux[VALID_BIT] = valid;
        rd_mux[MRDY_BIT]  = mrdy_q;
      end
      A_OPS:   for (int k = 0; k < NUM_FLAGS; k++) rd_mux[FLAG_POS[k]] = flags[k];
      A_IRQEN: for (int k = 0; k < NUM_FLAGS; k++) rd_mux[FLAG_POS[k]] = en[k];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrdy_q       <= 1'b0;
      rdata        <= '0;
      rvalid       <= 1'b0;
      engine_clear <= 1'b0;
    end else begin
      mrdy_q       <= master_rdy_i;
      rvalid       <= re;
      engine_clear <= srst;
      if (re) rdata <= rd_mux;
    end
  end

  // R1: every read strobe is answered on the next cycle
  p_read_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rvalid);

  // R5: the clear pulse follows a soft reset write
  p_clear_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> engine_clear);

endmodule

// File: rtl/engine_run_ctl.sv
module engine_run_ctl
  import erc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              master_rdy_i,
  input  logic              out_svc_evt,
  input  logic              in_svc_evt,
  input  logic              in_done_evt,
  output logic              move_ok,
  output logic              refill_ok,
  output logic              engine_clear,
  output logic              irq
);

  run_state_e cur_state;
  logic valid, st_req, srst, en_we;
  logic [1:0] st_code;
  logic [NUM_FLAGS-1:0] evt, clr, flags, en, en_wdata;

  assign evt = {in_done_evt, in_svc_evt, out_svc_evt};

  erc_state_seq #(.SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(st_req), .req_code(st_code),
    .srst(srst), .cur_state(cur_state), .valid(valid)
  );

  erc_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .srst(srst),
    .en_we(en_we), .en_wdata(en_wdata), .flags(flags), .en(en), .irq(irq)
  );

  erc_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .re(reg_re), .master_rdy_i(master_rdy_i), .cur_state(cur_state),
    .valid(valid), .flags(flags), .en(en), .st_req(st_req), .st_code(st_code),
    .srst(srst), .clr(clr), .en_we(en_we), .en_wdata(en_wdata),
    .rdata(reg_rdata), .rvalid(reg_rvalid), .engine_clear(engine_clear)
  );

  assign move_ok   = valid && (cur_state == ST_RUN);
  assign refill_ok = valid && (cur_state == ST_PAUSE);

  // R9: the two gates never open together
  p_gates_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(move_ok && refill_ok));

endmodule

// File: tb/engine_run_ctl_bench.sv
`timescale 1ns/1ps
module engine_run_ctl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic master_rdy_i = 1'b0, out_svc_evt = 1'b0, in_svc_evt = 1'b0, in_done_evt = 1'b0;
  logic move_ok, refill_ok, engine_clear, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  engine_run_ctl u_engine_run_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .master_rdy_i(master_rdy_i),
    .out_svc_evt(out_svc_evt), .in_svc_evt(in_svc_evt), .in_done_evt(in_done_evt),
    .move_ok(move_ok), .refill_ok(refill_ok), .engine_clear(engine_clear), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data returns
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) chk("R1 unexpected read", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    reg_addr = a; reg_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 move_ok after reset", move_ok, 0);
    chk("R9 refill_ok after reset", refill_ok, 0);
    chk("R8 irq after reset", irq, 0);
    chk("R5 engine_clear after reset", engine_clear, 0);
    rd(4'd0, 32'h4, "R1 state after reset");
    rd(4'd7, 32'h0, "R1 unmapped offset");
    // R10
    master_rdy_i = 1'b1;
    @(negedge clk);
    rd(4'd0, 32'h14, "R10 master ready");
    // R3 illegal moves
    wr(4'd0, 32'h3);
    rd(4'd0, 32'h14, "R3 pause from reset ignored");
    wr(4'd0, 32'h2);
    rd(4'd0, 32'h14, "R3 code 2 ignored");
    // R2 reset -> run
    wr(4'd0, 32'h1);
    rd(4'd0, 32'h10, "R2 settle cycle 1");
    rd(4'd0, 32'h10, "R2 settle cycle 2");
    rd(4'd0, 32'h15, "R2 run committed");
    chk("R9 move_ok in run", move_ok, 1);
    chk("R9 refill_ok in run", refill_ok, 0);
    // R3 run -> pause
    wr(4'd0, 32'h3);
    rd(4'd0, 32'h11, "R3 pause settle 1");
    rd(4'd0, 32'h11, "R3 pause settle 2");
    rd(4'd0, 32'h17, "R3 pause committed");
    chk("R9 refill_ok in pause", refill_ok, 1);
    chk("R9 move_ok in pause", move_ok, 0);
    // R4 write during settle ignored
    wr(4'd0, 32'h1);
    wr(4'd0, 32'h0);
    rd(4'd0, 32'h13, "R4 still settling");
    rd(4'd0, 32'h15, "R4 second write ignored");
    // R5 soft reset during settle
    wr(4'd0, 32'h3);
    wr(4'd1, 32'h1);
    chk("R5 engine_clear pulse", engine_clear, 1);
    rd(4'd0, 32'h14, "R5 forced reset");
    chk("R5 engine_clear one cycle", engine_clear, 0);
    rd(4'd0, 32'h14, "R5 pending cancelled");
    // R5 write of zero
    wr(4'd0, 32'h1);
    repeat (3) @(negedge clk);
    wr(4'd1, 32'h0);
    chk("R5 zero write no pulse", engine_clear, 0);
    rd(4'd0, 32'h15, "R5 zero write keeps run");
    // R6 flags
    out_svc_evt = 1'b1; @(negedge clk); out_svc_evt = 1'b0;
    rd(4'd2, 32'h100, "R6 output service flag");
    in_svc_evt = 1'b1; in_done_evt = 1'b1; @(negedge clk);
    in_svc_evt = 1'b0; in_done_evt = 1'b0;
    rd(4'd2, 32'hB00, "R6 all flags");
    wr(4'd2, 32'h100);
    rd(4'd2, 32'hA00, "R6 clear bit 8");
    wr(4'd2, 32'h0);
    rd(4'd2, 32'hA00, "R6 zero write no effect");
    wr(4'd2, 32'hA00);
    rd(4'd2, 32'h0, "R6 clear rest");
    // R7 collision
    in_svc_evt = 1'b1;
    wr(4'd2, 32'h200);
    in_svc_evt = 1'b0;
    rd(4'd2, 32'h200, "R7 set wins over clear");
    // R8 mask
    chk("R8 masked flag no irq", irq, 0);
    wr(4'd3, 32'h200);
    chk("R8 enabled flag irq", irq, 1);
    rd(4'd3, 32'h200, "R8 mask readback");
    repeat (2) @(negedge clk);
    chk("R8 irq level holds", irq, 1);
    wr(4'd2, 32'h200);
    chk("R8 irq drops on clear", irq, 0);
    in_done_evt = 1'b1; @(negedge clk); in_done_evt = 1'b0;
    chk("R8 disabled flag no irq", irq, 0);
    wr(4'd3, 32'h800);
    chk("R8 irq on newly enabled", irq, 1);
    wr(4'd1, 32'h1);
    chk("R5 srst clears irq", irq, 0);
    rd(4'd2, 32'h0, "R5 srst clears flags");
    rd(4'd3, 32'h800, "R8 mask kept over srst");
    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule